// File: doc/BRIEF.md
# Streaming Hamming Parity Code Generator

This block produces a three-byte single-error-correcting parity code for a data block of 256 bytes that streams in at one byte per clock. A byte is taken on each cycle where `valid_i` is high inside an open block. A `start_i` pulse opens a new block, clears every accumulator and sets the byte index to zero. Two kinds of parity are gathered along the way. Column parity is six bits that depend on bit positions within each byte. Line parity is two 8-bit registers that fold in the index of every byte whose weight is odd.

After the last byte of the block is taken, the block interleaves the two line registers into two bytes and inverts them. It packs the inverted column parity into a third byte and pulses `done_o` for one cycle. The three code bytes then hold until the next block completes. A reader compares a stored code with a freshly computed one. The XOR of the two codes gives the byte and bit position of a single flipped bit. `swap_order_i` chooses which of the two line-parity bytes appears first, because some media store them in the opposite order.

Top module: `ecc_stream_gen`

## Requirements
- R1: After reset `done_o` is 0 and all three code outputs read 8'hFF.
- R2: Column bit c0 is the XOR of data bits 0,2,4,6 and c1 is the XOR of bits 1,3,5,7. c2 covers bits 0,1,4,5 and c3 covers bits 2,3,6,7. c4 covers bits 3:0 and c5 covers bits 7:4. Each is XOR-accumulated over the block. `code2_o` = {~c5..~c0, 1, 1}.
- R3: For each accepted byte with odd weight, its index i (0..255) is XORed into line register P and ~i is XORed into line register Q. P and Q therefore always differ by 8'h00 or 8'hFF.
- R4: Byte HI = {P7,Q7,P6,Q6,P5,Q5,P4,Q4} and byte LO = {P3,Q3,P2,Q2,P1,Q1,P0,Q0}. With `swap_order_i` = 0, `code0_o` = ~HI and `code1_o` = ~LO.
- R5: With `swap_order_i` = 1, `code0_o` = ~LO and `code1_o` = ~HI. The selection acts on the presented bytes in the same cycle, with no new block needed.
- R6: `done_o` is high for exactly one cycle, on the cycle after the clock edge that takes the 256th byte. The new code values appear in that same cycle.
- R7: Cycles with `valid_i` low inside a block take no byte and do not advance the index.
- R8: A `start_i` pulse in the middle of a block discards the parity gathered so far and restarts the index at zero.
- R9: Bytes with `valid_i` high while no block is open are ignored. They raise no `done_o` and leave the code outputs unchanged.
- R10: Between `done_o` pulses the code bytes do not change, apart from the reordering by `swap_order_i`.
- R11: A byte presented with `valid_i` in the same cycle as `start_i` is taken as index 0 of the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new block and clears the accumulators |
| valid_i | input | 1 | `data_i` carries a byte this cycle |
| data_i | input | 8 | Data byte |
| swap_order_i | input | 1 | 1 places the low line-parity byte first |
| code0_o | output | 8 | First code byte |
| code1_o | output | 8 | Second code byte |
| code2_o | output | 8 | Column parity code byte |
| done_o | output | 1 | One-cycle pulse when a new code is presented |

## Verification
The hardest case to reach is a restart in the middle of a block. Here the stale line registers and the column parity must vanish, while the byte taken together with the new `start_i` pulse must still count as index 0. The bench streams 100 bytes of noise and then starts a full block without a gap. It expects exactly the code of that block. It also streams stray bytes after completion and inserts idle cycles inside a block, to show that only bytes taken inside an open block move the index.

// File: rtl/ecc_stream_pkg.sv
package ecc_stream_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 8;
    localparam int COL_W  = 6;

    typedef enum logic {
        BLK_IDLE = 1'b0,
        BLK_RUN  = 1'b1
    } blk_state_t;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             odd;
    } byte_par_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] cmp;
        logic [COL_W-1:0] col;
    } par_acc_t;

    // Bit b of the data byte contributes to column bit k when bit (k/2) of b equals k%2.
    function automatic logic [BYTE_W-1:0] col_mask(input int k);
        logic [BYTE_W-1:0] m;
        for (int b = 0; b < BYTE_W; b++) begin
            m[b] = (((b >> (k / 2)) & 1) == (k % 2));
        end
        return m;
    endfunction

    // Pairs hi_src[k] above lo_src[k], highest pair first.
    function automatic logic [7:0] weave(input logic [3:0] hi_src, input logic [3:0] lo_src);
        logic [7:0] w;
        for (int k = 0; k < 4; k++) begin
            w[2*k+1] = hi_src[k];
            w[2*k]   = lo_src[k];
        end
        return w;
    endfunction

endpackage

// File: rtl/ecc_byte_parity.sv
module ecc_byte_parity
    import ecc_stream_pkg::*;
(
    input  logic [BYTE_W-1:0] data_i,
    output byte_par_t         par_o
);

    logic [COL_W-1:0] col_w;

    for (genvar k = 0; k < COL_W; k++) begin : g_col
        localparam logic [BYTE_W-1:0] MASK = col_mask(k);
        assign col_w[k] = ^(data_i & MASK);
    end

    assign par_o.col = col_w;
    assign par_o.odd = ^data_i;

endmodule

// File: rtl/ecc_block_ctrl.sv
module ecc_block_ctrl
    import ecc_stream_pkg::*;
#(
    parameter int BLOCK_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             valid_i,
    output logic             clear_o,
    output logic             accept_o,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam int CNT_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_BYTES - 1);

    blk_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cur_idx;

    assign cur_idx  = start_i ? '0 : cnt_q;
    assign accept_o = valid_i && (start_i || (state_q == BLK_RUN));
    assign last_o   = accept_o && (cur_idx == LAST_IDX);
    assign clear_o  = start_i;
    assign idx_o    = IDX_W'(cur_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BLK_IDLE;
            cnt_q   <= '0;
        end else if (accept_o) begin
            if (last_o) begin
                state_q <= BLK_IDLE;
                cnt_q   <= '0;
            end else begin
                state_q <= BLK_RUN;
                cnt_q   <= cur_idx + 1'b1;
            end
        end else if (start_i) begin
            state_q <= BLK_RUN;
            cnt_q   <= '0;
        end
    end

endmodule

// File: rtl/ecc_parity_accum.sv
module ecc_parity_accum
    import ecc_stream_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             accept_i,
    input  logic [IDX_W-1:0] idx_i,
    input  byte_par_t        par_i,
    output par_acc_t         acc_next_o,
    output par_acc_t         acc_q_o
);

    par_acc_t acc_q;
    par_acc_t base;
    par_acc_t nxt;

    always_comb begin
        base = clear_i ? '0 : acc_q;
        nxt  = base;
        if (accept_i) begin
            nxt.col = base.col ^ par_i.col;
            if (par_i.odd) begin
                nxt.idx = base.idx ^ idx_i;
                nxt.cmp = base.cmp ^ ~idx_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= nxt;
        end
    end

    assign acc_next_o = nxt;
    assign acc_q_o    = acc_q;

endmodule

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
    import ecc_stream_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  par_acc_t    acc_i,
    input  logic        swap_i,
    output logic [7:0]  code0_o,
    output logic [7:0]  code1_o,
    output logic [7:0]  code2_o,
    output logic        done_o
);

    logic [7:0] hi_q;
    logic [7:0] lo_q;
    logic [7:0] col_q;
    logic       done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= 8'hFF;
            lo_q   <= 8'hFF;
            col_q  <= 8'hFF;
            done_q <= 1'b0;
        end else begin
            done_q <= load_i;
            if (load_i) begin
                hi_q  <= ~weave(acc_i.idx[7:4], acc_i.cmp[7:4]);
                lo_q  <= ~weave(acc_i.idx[3:0], acc_i.cmp[3:0]);
                col_q <= {~acc_i.col, 2'b11};
            end
        end
    end

    assign code0_o = swap_i ? lo_q : hi_q;
    assign code1_o = swap_i ? hi_q : lo_q;
    assign code2_o = col_q;
    assign done_o  = done_q;

endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
    import ecc_stream_pkg::*;
#(
    parameter int BLOCK_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       valid_i,
    input  logic [7:0] data_i,
    input  logic       swap_order_i,
    output logic [7:0] code0_o,
    output logic [7:0] code1_o,
    output logic [7:0] code2_o,
    output logic       done_o
);

    logic             clear_w;
    logic             accept_w;
    logic             last_w;
    logic [IDX_W-1:0] idx_w;
    byte_par_t        par_w;
    par_acc_t         acc_next_w;
    par_acc_t         acc_q_w;
    logic [IDX_W-1:0] line_idx_q;
    logic [IDX_W-1:0] line_cmp_q;

    ecc_block_ctrl #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .valid_i  (valid_i),
        .clear_o  (clear_w),
        .accept_o (accept_w),
        .last_o   (last_w),
        .idx_o    (idx_w)
    );

    ecc_byte_parity u_bpar (
        .data_i (data_i),
        .par_o  (par_w)
    );

    ecc_parity_accum u_acc (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear_w),
        .accept_i   (accept_w),
        .idx_i      (idx_w),
        .par_i      (par_w),
        .acc_next_o (acc_next_w),
        .acc_q_o    (acc_q_w)
    );

    ecc_code_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .load_i  (last_w),
        .acc_i   (acc_next_w),
        .swap_i  (swap_order_i),
        .code0_o (code0_o),
        .code1_o (code1_o),
        .code2_o (code2_o),
        .done_o  (done_o)
    );

    assign line_idx_q = acc_q_w.idx;
    assign line_cmp_q = acc_q_w.cmp;

endmodule

// File: rtl/ecc_stream_chk.sv
module ecc_stream_chk #(
    parameter int BLOCK_BYTES = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       valid_i,
    input logic       swap_order_i,
    input logic [7:0] code0_o,
    input logic [7:0] code1_o,
    input logic [7:0] code2_o,
    input logic       done_o,
    input logic [7:0] line_idx_q,
    input logic [7:0] line_cmp_q
);

    localparam int N_W = $clog2(BLOCK_BYTES + 1);

    logic           open_q;
    logic [N_W-1:0] n_q;
    logic           taken;
    logic [N_W-1:0] pos;

    assign taken = valid_i && (start_i || open_q);
    assign pos   = start_i ? '0 : n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            n_q    <= '0;
        end else if (taken) begin
            if (pos == N_W'(BLOCK_BYTES - 1)) begin
                open_q <= 1'b0;
                n_q    <= '0;
            end else begin
                open_q <= 1'b1;
                n_q    <= pos + 1'b1;
            end
        end else if (start_i) begin
            open_q <= 1'b1;
            n_q    <= '0;
        end
    end

    // R6: pulse is one cycle wide
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6, R7, R9: a pulse only follows the taking of the final byte
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(taken && (pos == N_W'(BLOCK_BYTES - 1))));

    // R10: stored code stays put between pulses
    p_codes_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(code2_o) && $stable(code0_o ^ code1_o)));

    // R5: flipping the order swaps the presented bytes at once
    p_swap_order_r5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(swap_order_i) && !done_o) |-> (code0_o == $past(code1_o)));

    // R3: the two line registers are complements up to the parity of odd bytes
    p_line_pair_r3: assert property (@(posedge clk) disable iff (rst)
        ((line_idx_q ^ line_cmp_q) == 8'h00) || ((line_idx_q ^ line_cmp_q) == 8'hFF));

endmodule

bind ecc_stream_gen ecc_stream_chk #(.BLOCK_BYTES(BLOCK_BYTES)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .valid_i      (valid_i),
    .swap_order_i (swap_order_i),
    .code0_o      (code0_o),
    .code1_o      (code1_o),
    .code2_o      (code2_o),
    .done_o       (done_o),
    .line_idx_q   (line_idx_q),
    .line_cmp_q   (line_cmp_q)
);

// File: tb/test_ecc_stream_gen.sv
`timescale 1ns/1ps
module test_ecc_stream_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic       valid_i;
    logic [7:0] data_i;
    logic       swap_order_i;
    logic [7:0] code0_o;
    logic [7:0] code1_o;
    logic [7:0] code2_o;
    logic       done_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    logic [7:0] blk [256];

    always #2.5 clk = ~clk;

    ecc_stream_gen i_ecc_stream_gen (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .valid_i      (valid_i),
        .data_i       (data_i),
        .swap_order_i (swap_order_i),
        .code0_o      (code0_o),
        .code1_o      (code1_o),
        .code2_o      (code2_o),
        .done_o       (done_o)
    );

    task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference code computed from the requirement text.
    task automatic model(input logic swap, output logic [7:0] e0, output logic [7:0] e1, output logic [7:0] e2);
        logic [7:0] p, q, hi, lo;
        logic [5:0] c;
        p = 0; q = 0; c = 0;
        for (int i = 0; i < 256; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (blk[i][b]) begin
                    c[0] ^= (b % 2 == 0);
                    c[1] ^= (b % 2 == 1);
                    c[2] ^= ((b & 2) == 0);
                    c[3] ^= ((b & 2) != 0);
                    c[4] ^= (b < 4);
                    c[5] ^= (b >= 4);
                end
            end
            if (^blk[i]) begin
                p ^= 8'(i);
                q ^= ~8'(i);
            end
        end
        for (int k = 0; k < 4; k++) begin
            hi[2*k+1] = p[k+4]; hi[2*k] = q[k+4];
            lo[2*k+1] = p[k];   lo[2*k] = q[k];
        end
        e0 = swap ? ~lo : ~hi;
        e1 = swap ? ~hi : ~lo;
        e2 = {~c, 2'b11};
    endtask

    // Streams blk[] as one block; gap_every > 0 inserts idle cycles.
    task automatic send_block(input string req, input int gap_every);
        logic [7:0] e0, e1, e2;
        for (int i = 0; i < 256; i++) begin
            if (gap_every > 0 && (i % gap_every) == 3) begin
                @(negedge clk); start_i = 0; valid_i = 0; data_i = 8'hA5;
            end
            @(negedge clk);
            start_i = (i == 0);
            valid_i = 1;
            data_i  = blk[i];
            if (i > 0) check8(req, "done before last byte", {7'b0, done_o}, 8'h00);
        end
        @(posedge clk); #1;
        model(swap_order_i, e0, e1, e2);
        check8("R6", "done after last byte", {7'b0, done_o}, 8'h01);
        check8(req, "code0", code0_o, e0);
        check8(req, "code1", code1_o, e1);
        check8(req, "code2", code2_o, e2);
        @(negedge clk); start_i = 0; valid_i = 0;
        @(posedge clk); #1;
        check8("R6", "done one cycle wide", {7'b0, done_o}, 8'h00);
    endtask

    task automatic t_reset();
        rst = 1; start_i = 0; valid_i = 0; data_i = 0; swap_order_i = 0;
        repeat (3) @(posedge clk);
        #1;
        check8("R1", "reset done", {7'b0, done_o}, 8'h00);
        check8("R1", "reset code0", code0_o, 8'hFF);
        check8("R1", "reset code1", code1_o, 8'hFF);
        check8("R1", "reset code2", code2_o, 8'hFF);
        @(negedge clk); rst = 0;
    endtask

    task automatic t_zero();
        for (int i = 0; i < 256; i++) blk[i] = 8'h00;
        send_block("R2", 0);
        check8("R2", "all-zero code2", code2_o, 8'hFF);
    endtask

    task automatic t_first_byte();
        // R11: byte with start is index 0, so 0 folds into P and FF into Q
        for (int i = 0; i < 256; i++) blk[i] = 8'h00;
        blk[0] = 8'h01;
        send_block("R11", 0);
        check8("R11", "first-byte code0", code0_o, 8'hAA);
        check8("R11", "first-byte code2", code2_o, 8'hAB);
    endtask

    task automatic t_single_odd();
        for (int i = 0; i < 256; i++) blk[i] = 8'h00;
        blk[8'h5A] = 8'h80;
        send_block("R3", 0);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < 256; i++) blk[i] = 8'((i * 37 + 5) ^ (i >> 3));
        send_block("R4", 0);
    endtask

    task automatic t_swap();
        logic [7:0] e0, e1, e2;
        @(negedge clk); swap_order_i = 1; #1;
        model(1'b1, e0, e1, e2);
        check8("R5", "live swap code0", code0_o, e0);
        check8("R5", "live swap code1", code1_o, e1);
        for (int i = 0; i < 256; i++) blk[i] = 8'(i * 113 + 29);
        send_block("R5", 0);
        @(negedge clk); swap_order_i = 0;
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 256; i++) blk[i] = 8'(i ^ 8'h6C);
        send_block("R7", 5);
    endtask

    task automatic t_restart();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); start_i = (i == 0); valid_i = 1; data_i = 8'(i * 7 + 1);
        end
        for (int i = 0; i < 256; i++) blk[i] = 8'((i * 3) ^ 8'h91);
        send_block("R8", 0);
    endtask

    task automatic t_stray();
        logic [7:0] h0, h1, h2;
        h0 = code0_o; h1 = code1_o; h2 = code2_o;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); start_i = 0; valid_i = 1; data_i = 8'(i + 1);
            #1;
            check8("R9", "stray done", {7'b0, done_o}, 8'h00);
        end
        @(negedge clk); valid_i = 0;
        @(posedge clk); #1;
        check8("R9", "stray code0", code0_o, h0);
        check8("R10", "stray code1", code1_o, h1);
        check8("R10", "stray code2", code2_o, h2);
    endtask

    initial begin
        t_reset();
        t_zero();
        t_first_byte();
        t_single_odd();
        t_ramp();
        t_swap();
        t_gaps();
        t_restart();
        t_stray();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule